// File: doc/BRIEF.md
# Pseudo-Random Pixel Dissolve Controller

This block wipes a stored picture off a framebuffer by overwriting its pixels one at a time in a scrambled order, until every pixel holds one fixed fade colour. It runs on the system clock. Its only inputs are a single-cycle frame-start pulse and reset. It drives the write side of a framebuffer: a write strobe, a linear row-major pixel address and a colour index. The framebuffer memory, the display readout and any palette lookup sit outside it.

A shift-register sequence generator supplies the addresses. The generator's values that fall beyond the buffer are skipped. The generator never produces zero, so the block writes address zero once after the sequence has wrapped back to its seed. Writing stays idle until a chosen number of frames has gone by. After that, writes are issued at a fixed interval of system cycles. A sticky done flag goes high when the last pixel has been written.

Top module: `pixel_dissolve`

## Requirements
- R1: While `rst_n` is low, `wr_en` and `fade_done` are 0. Reset is asserted asynchronously and released through a two-stage synchronizer.
- R2: No write is issued before `WAIT_FRAMES` frame-start pulses have been counted after reset. The frame count saturates there, so later pulses change nothing.
- R3: The first write appears on the `RATE`-th rising edge after the edge that captured the last needed frame pulse. Later writes follow every `RATE` cycles, provided `RATE` is longer than the longest run of out-of-range sequence values.
- R4: `wr_en` is high for one cycle per write. `wr_addr` and `wr_color` are registered and change only on the edge that raises `wr_en`. On every other cycle `wr_en` is 0.
- R5: Every write carries the colour index `FADE_COLOR`.
- R6: Addresses come from a Fibonacci shift register. The next state is `{s[LEN-2:0], ^(s & TAPS)}`. The register resets to `LFSR_SEED`, and a seed of zero is replaced by all ones. A value of `FB_WIDTH*FB_HEIGHT` or more produces no write. The register then steps again on the next cycle without waiting for the rate interval.
- R7: Over one complete fade, each address from 0 to `FB_WIDTH*FB_HEIGHT-1` is written exactly once. The total is `FB_WIDTH*FB_HEIGHT` writes, and no address is ever out of range.
- R8: Once the register has returned to its seed, the next write goes to address 0. This is the last write, and `fade_done` rises on the same edge.
- R9: `fade_done` stays high until reset, and no write is issued while it is high.
- R10: A reset part-way through a fade or after it restarts the process: the frame wait applies again and a full fade follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of each displayed frame |
| wr_en | output | 1 | Framebuffer write strobe |
| wr_addr | output | ADDR_W (15) | Linear row-major pixel address |
| wr_color | output | PIX_BITS (4) | Colour index to store |
| fade_done | output | 1 | Sticky flag: every pixel has been overwritten |

## Verification
The bound checker watches the properties that hold on every cycle. These are the single-cycle strobe, the address held between writes, the fixed colour, the in-range address, no write before enough frames, `fade_done` staying high with no write after it, and `fade_done` rising only together with a write to address 0. Some properties can only be shown by scenarios in the bench: exact cover of every address once, the first-write latency, the even spacing of writes despite skipped sequence values, and a fade restarting after a reset in mid-fade. The bench shows these with a scoreboard on a small 8x6 buffer driven by a 6-bit sequence, which it runs to completion twice.

// File: rtl/fade_pkg.sv
package fade_pkg;

  // Bits needed to hold values 0..n-1, never less than one.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/fade_rst_sync.sv
module fade_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/fade_frame_gate.sv
module fade_frame_gate #(
  parameter int unsigned WAIT_FRAMES = 300
) (
  input  logic clk,
  input  logic arst_n,
  input  logic frame_start,
  output logic active
);

  localparam int unsigned CW = fade_pkg::cnt_width(WAIT_FRAMES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_FRAMES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_limit;

  assign at_limit = (cnt_q == LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (frame_start && !at_limit) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign active = at_limit;

endmodule

// File: rtl/fade_rate_timer.sv
module fade_rate_timer #(
  parameter int unsigned RATE = 2000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned CW = fade_pkg::cnt_width(RATE);
  localparam logic [CW-1:0] LAST = CW'(RATE - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick = run && wrap;

endmodule

// File: rtl/fade_addr_seq.sv
module fade_addr_seq #(
  parameter int unsigned LEN    = 15,
  parameter logic [LEN-1:0] TAPS = 15'b110000000000000,
  parameter logic [LEN-1:0] SEED = '1,
  parameter int unsigned PIXELS = 19200
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic           run,
  input  logic           advance,
  output logic [LEN-1:0] cur,
  output logic           cur_ok,
  output logic           zero_phase
);

  localparam logic [LEN-1:0] SEED_EFF = (SEED == '0) ? '1 : SEED;

  logic [LEN-1:0] cur_q, cur_d, nxt;
  logic           zero_q, zero_d;
  logic           feedback;
  logic           step;

  assign feedback = ^(cur_q & TAPS);
  assign nxt      = {cur_q[LEN-2:0], feedback};
  assign cur_ok   = (32'(cur_q) < PIXELS);

  // Step when the current value is consumed or must be skipped.
  assign step = run && !zero_q && (!cur_ok || advance);

  always_comb begin
    cur_d  = cur_q;
    zero_d = zero_q;
    if (step) begin
      cur_d = nxt;
      if (nxt == SEED_EFF) zero_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cur_q  <= SEED_EFF;
      zero_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      zero_q <= zero_d;
    end
  end

  assign cur        = cur_q;
  assign zero_phase = zero_q;

endmodule

// File: rtl/fade_write_stage.sv
module fade_write_stage #(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned PIX_BITS = 4,
  parameter logic [PIX_BITS-1:0] FADE_COLOR = 4'h7
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                run,
  input  logic                tick,
  input  logic [ADDR_W-1:0]   cur_addr,
  input  logic                cur_ok,
  input  logic                zero_phase,
  output logic                advance,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [PIX_BITS-1:0] wr_color,
  output logic                done
);

  logic                pend_q, pend_d;
  logic                en_q, en_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [PIX_BITS-1:0] color_q, color_d;
  logic                done_q, done_d;
  logic                want, fire;

  assign want    = pend_q || tick;
  assign fire    = run && want && (zero_phase || cur_ok);
  assign advance = fire && !zero_phase;

  always_comb begin
    pend_d  = run ? (want && !fire) : 1'b0;
    en_d    = fire;
    addr_d  = addr_q;
    color_d = color_q;
    done_d  = done_q;
    if (fire) begin
      addr_d  = zero_phase ? '0 : cur_addr;
      color_d = FADE_COLOR;
      if (zero_phase) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
      addr_q  <= '0;
      color_q <= '0;
      done_q  <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      en_q    <= en_d;
      addr_q  <= addr_d;
      color_q <= color_d;
      done_q  <= done_d;
    end
  end

  assign wr_en    = en_q;
  assign wr_addr  = addr_q;
  assign wr_color = color_q;
  assign done     = done_q;

endmodule

// File: rtl/pixel_dissolve.sv
module pixel_dissolve #(
  parameter int unsigned FB_WIDTH    = 160,
  parameter int unsigned FB_HEIGHT   = 120,
  parameter int unsigned PIX_BITS    = 4,
  parameter logic [PIX_BITS-1:0] FADE_COLOR = 4'h7,
  parameter int unsigned WAIT_FRAMES = 300,
  parameter int unsigned RATE        = 2000,
  parameter int unsigned LFSR_LEN    = 15,
  parameter logic [LFSR_LEN-1:0] LFSR_TAPS = 15'b110000000000000,
  parameter logic [LFSR_LEN-1:0] LFSR_SEED = '1,
  localparam int unsigned PIXELS = FB_WIDTH * FB_HEIGHT,
  localparam int unsigned ADDR_W = fade_pkg::cnt_width(PIXELS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [PIX_BITS-1:0] wr_color,
  output logic                fade_done
);

  logic                arst_n;
  logic                active, run, tick, advance;
  logic [LFSR_LEN-1:0] cur;
  logic                cur_ok, zero_phase;
  logic                done;

  assign run       = active && !done;
  assign fade_done = done;

  fade_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (arst_n)
  );

  fade_frame_gate #(.WAIT_FRAMES(WAIT_FRAMES)) u_gate (
    .clk         (clk),
    .arst_n      (arst_n),
    .frame_start (frame_start),
    .active      (active)
  );

  fade_rate_timer #(.RATE(RATE)) u_rate (
    .clk    (clk),
    .arst_n (arst_n),
    .run    (run),
    .tick   (tick)
  );

  fade_addr_seq #(
    .LEN    (LFSR_LEN),
    .TAPS   (LFSR_TAPS),
    .SEED   (LFSR_SEED),
    .PIXELS (PIXELS)
  ) u_seq (
    .clk        (clk),
    .arst_n     (arst_n),
    .run        (run),
    .advance    (advance),
    .cur        (cur),
    .cur_ok     (cur_ok),
    .zero_phase (zero_phase)
  );

  fade_write_stage #(
    .ADDR_W     (ADDR_W),
    .PIX_BITS   (PIX_BITS),
    .FADE_COLOR (FADE_COLOR)
  ) u_wr (
    .clk        (clk),
    .arst_n     (arst_n),
    .run        (run),
    .tick       (tick),
    .cur_addr   (cur[ADDR_W-1:0]),
    .cur_ok     (cur_ok),
    .zero_phase (zero_phase),
    .advance    (advance),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_color   (wr_color),
    .done       (done)
  );

endmodule

// File: rtl/pixel_dissolve_chk.sv
module pixel_dissolve_chk #(
  parameter int unsigned PIXELS      = 19200,
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned PIX_BITS    = 4,
  parameter logic [PIX_BITS-1:0] FADE_COLOR = 4'h7,
  parameter int unsigned WAIT_FRAMES = 300,
  parameter int unsigned RATE        = 2000
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_start,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [PIX_BITS-1:0] wr_color,
  input logic                fade_done
);

  int unsigned frames_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frames_seen <= 0;
    else if (frame_start && frames_seen < WAIT_FRAMES) frames_seen <= frames_seen + 1;
  end

  a_r2_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (frames_seen >= WAIT_FRAMES));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (RATE > 1 && wr_en) |=> !wr_en);

  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> ($stable(wr_addr) && $stable(wr_color)));

  a_r5_fade_color: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_color == FADE_COLOR));

  a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < PIXELS));

  a_r8_done_with_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fade_done) |-> (wr_en && wr_addr == '0));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fade_done |=> fade_done);

  a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    fade_done |=> !wr_en);

endmodule

bind pixel_dissolve pixel_dissolve_chk #(
  .PIXELS      (PIXELS),
  .ADDR_W      (ADDR_W),
  .PIX_BITS    (PIX_BITS),
  .FADE_COLOR  (FADE_COLOR),
  .WAIT_FRAMES (WAIT_FRAMES),
  .RATE        (RATE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_color    (wr_color),
  .fade_done   (fade_done)
);

// File: tb/pixel_dissolve_tb.sv
module pixel_dissolve_tb;

  localparam int W    = 8;
  localparam int H    = 6;
  localparam int PIX  = W * H;
  localparam int AW   = 6;
  localparam int WAIT = 3;
  localparam int RATE = 20;
  localparam logic [3:0] COL = 4'hA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [3:0]    wr_color;
  logic          fade_done;

  pixel_dissolve #(
    .FB_WIDTH    (W),
    .FB_HEIGHT   (H),
    .PIX_BITS    (4),
    .FADE_COLOR  (COL),
    .WAIT_FRAMES (WAIT),
    .RATE        (RATE),
    .LFSR_LEN    (6),
    .LFSR_TAPS   (6'b110000),
    .LFSR_SEED   (6'b000000)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_color    (wr_color),
    .fade_done   (fade_done)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int nwr = 0;
  int last_wc = 0;
  int last_addr = -1;
  bit seen [PIX];
  bit done_prev = 1'b0;
  bit en_prev = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic observe();
    if (wr_en) begin
      nwr++;
      check(int'(wr_addr) < PIX, "R7", "address in range", int'(wr_addr), PIX - 1);
      if (int'(wr_addr) < PIX) begin
        check(!seen[wr_addr], "R7", "address written once", int'(wr_addr), -1);
        seen[wr_addr] = 1'b1;
      end
      check(wr_color == COL, "R5", "fade colour", int'(wr_color), int'(COL));
      if (nwr > 1) check(cyc - last_wc == RATE, "R3", "write spacing", cyc - last_wc, RATE);
      check(!en_prev, "R4", "strobe one cycle", 1, 0);
      check(!done_prev, "R9", "no write after done", 1, 0);
      last_wc = cyc;
      last_addr = int'(wr_addr);
    end
    if (fade_done && !done_prev)
      check(wr_en && wr_addr == '0, "R8", "done rises with zero write", int'(wr_addr), 0);
    if (done_prev && !fade_done && rst_n)
      check(1'b0, "R9", "done sticky", 0, 1);
    done_prev = fade_done;
    en_prev = wr_en;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    observe();
  endtask

  task automatic pulse();
    frame_start = 1'b1;
    step();
    frame_start = 1'b0;
  endtask

  // stop_after = 0 runs the whole fade, otherwise stop after that many writes.
  task automatic run_fade(input int stop_after);
    int pulse_cyc;
    int first_wc;
    int limit;
    for (int i = 0; i < PIX; i++) seen[i] = 1'b0;
    nwr = 0;
    for (int i = 0; i < WAIT - 1; i++) begin
      pulse();
      repeat (5) step();
    end
    repeat (3 * RATE) step();
    check(nwr == 0, "R2", "no write before frame wait", nwr, 0);
    pulse();
    pulse_cyc = cyc;
    first_wc = -1;
    limit = 0;
    while (!fade_done && limit < (PIX + 20) * RATE) begin
      if (limit % 37 == 36) pulse();
      else step();
      limit++;
      if (first_wc < 0 && nwr > 0) begin
        first_wc = last_wc;
        check(first_wc - pulse_cyc == RATE, "R3", "first write latency",
              first_wc - pulse_cyc, RATE);
      end
      if (stop_after > 0 && nwr >= stop_after) break;
    end
    if (stop_after == 0) begin
      check(fade_done, "R9", "done raised", int'(fade_done), 1);
      check(nwr == PIX, "R7", "total writes", nwr, PIX);
      check(last_addr == 0, "R8", "last write address", last_addr, 0);
      for (int i = 0; i < PIX; i++)
        if (!seen[i]) check(1'b0, "R7", "address missed", i, i);
      check(seen[0], "R6", "address zero reached", int'(seen[0]), 1);
      repeat (4 * RATE) step();
      check(fade_done && !wr_en, "R9", "done held, quiet", int'(fade_done), 1);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) step();
    check(!wr_en, "R1", "wr_en in reset", int'(wr_en), 0);
    check(!fade_done, "R1", "done in reset", int'(fade_done), 0);
    rst_n = 1'b1;
    repeat (4) step();

    // R6: seed of zero replaced by all ones; full fade from reset.
    run_fade(0);

    // R1: asynchronous assertion clears outputs without a clock edge.
    #1 rst_n = 1'b0;
    #1 check(!fade_done && !wr_en, "R1", "async clear", int'(fade_done), 0);
    done_prev = 1'b0;
    en_prev = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R10: partial fade, reset in mid-fade, then a complete fade again.
    run_fade(5);
    check(nwr == 5, "R10", "partial writes", nwr, 5);
    #1 rst_n = 1'b0;
    #1 check(!wr_en, "R10", "strobe cleared by reset", int'(wr_en), 0);
    done_prev = 1'b0;
    en_prev = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    repeat (4) step();
    run_fade(0);
    check(nwr == PIX, "R10", "full fade after reset", nwr, PIX);

    finish_run();
  end

endmodule